// File: doc/BRIEF.md
# Privileged Status Register with Mode Decoder

This block is the status control register of a processor's system-control coprocessor, together with the logic that turns its stored fields into live control signals. Privileged software writes the register through a single-cycle write port and can read the stored value back at any time. The register holds a 2-bit privilege-mode field, four coprocessor-usability bits, a reverse-endian bit, an 8-bit interrupt mask and a global interrupt enable. All other bit positions, including a reserved reduced-power bit, read as zero and cannot be written.

The decoded outputs follow the stored value directly. They are the effective privilege mode, a usable flag for coprocessors 0 to 2, an extended-ISA-available flag, the effective data endianness, and one interrupt request formed from eight pending lines. The decode applies four special rules. The undefined mode encoding behaves as user mode. Coprocessor 0 is always usable in kernel mode. The top usability bit is reused as the extended-ISA enable for user mode. Endian reversal applies only in user mode. The base endianness comes from a pin that is captured once after reset.

Top module: `sysctl_status_reg`

## Requirements
- R1: After reset, rd_data_o reads 0, mode_o reports kernel (2'b00), the interrupt mask and global enable are clear, and irq_req_o is 0 for any pending pattern.
- R2: When wr_en_i is high at a rising clock edge, rd_data_o shows wr_data_i & 32'hF200_FF19 from that edge on. The field layout is: bit 0 global interrupt enable, bits 4:3 mode, bits 15:8 interrupt mask (bit 8 masks line 0), bit 25 reverse-endian, bits 31:28 usability bits 3..0.
- R3: Bit 27 (reduced power) and every other bit outside 32'hF200_FF19 always read 0, and writing 1 to them has no effect.
- R4: The mode field decodes as 2'b00 kernel, 2'b01 supervisor and 2'b10 user. The encoding 2'b11 is reported on mode_o as user (2'b10), so mode_o never shows 2'b11.
- R5: cp_usable_o[0] is 1 when usability bit 0 is 1 or the mode is kernel. cp_usable_o[2:1] equal usability bits 2:1 in every mode.
- R6: ext_isa_o is 1 in kernel and supervisor modes whatever bit 31 holds. In user mode it equals bit 31.
- R7: big_endian_o (1 = big) equals the captured base endianness, except in user mode with bit 25 set, where it is the inverse.
- R8: The base endianness is taken from base_big_endian_i at the first rising edge after reset is released. Later changes of that pin have no effect until the next reset.
- R9: irq_req_o is 1 exactly when bit 0 is 1 and at least one line i has both irq_pend_i[i] and mask bit i set.
- R10: While wr_en_i is low, rd_data_o holds its value whatever wr_data_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Stored register value |
| base_big_endian_i | input | 1 | Base endianness select, 1 = big, captured after reset |
| irq_pend_i | input | 8 | Pending interrupt lines |
| mode_o | output | 2 | Effective privilege mode (00 kernel, 01 supervisor, 10 user) |
| cp_usable_o | output | 3 | Usable flags for coprocessors 0..2 |
| ext_isa_o | output | 1 | Extended instruction set available |
| big_endian_o | output | 1 | Effective data endianness, 1 = big |
| irq_req_o | output | 1 | Masked and enabled interrupt request |

## Verification
The assertions check the following rules on every cycle: the write-then-readback rule, the hold rule when no write occurs, the zero reserved bits, the absence of 2'b11 on the mode output, coprocessor 0 being usable in kernel mode, extended-ISA availability outside user mode, endianness following the base outside reversed user mode, and irq_req_o never rising without an enabled, masked pending line. Only the bench scenarios show the following behaviour: the exact decoded values for each mode and usability combination, the inversion in user mode, the one-time capture of the base pin across two resets, and the reset contents of the register.

// File: rtl/stat_cfg_pkg.sv
package stat_cfg_pkg;

  typedef enum logic [1:0] {
    MODE_KERNEL = 2'b00,
    MODE_SUPER  = 2'b01,
    MODE_USER   = 2'b10,
    MODE_RSVD   = 2'b11
  } priv_mode_e;

  localparam int unsigned REG_W    = 32;
  localparam int unsigned IRQ_N    = 8;
  localparam int unsigned CU_N     = 4;

  localparam int unsigned IE_BIT   = 0;
  localparam int unsigned MODE_LSB = 3;
  localparam int unsigned IM_LSB   = 8;
  localparam int unsigned RE_BIT   = 25;
  localparam int unsigned RP_BIT   = 27;
  localparam int unsigned CU_LSB   = 28;
  localparam int unsigned EXT_BIT  = CU_LSB + CU_N - 1;

  localparam logic [REG_W-1:0] WR_MASK =
      (REG_W'({CU_N{1'b1}})  << CU_LSB)
    | (REG_W'(1)             << RE_BIT)
    | (REG_W'({IRQ_N{1'b1}}) << IM_LSB)
    | (REG_W'(2'b11)         << MODE_LSB)
    | (REG_W'(1)             << IE_BIT);

endpackage

// File: rtl/stat_store.sv
module stat_store
  import stat_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] stat_q
);

  logic [REG_W-1:0] stat_d;

  // Only implemented fields take write data; reserved bits stay zero.
  always_comb begin
    stat_d = wr_data & WR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (wr_en) begin
      stat_q <= stat_d;
    end
  end

endmodule

// File: rtl/stat_base_endian.sv
module stat_base_endian (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_be,
  output logic base_be
);

  logic captured_q;
  logic base_q;
  logic capture_en;

  always_comb begin
    capture_en = !captured_q;
    // Before the first capture edge the pin value passes through.
    base_be    = captured_q ? base_q : pin_be;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      captured_q <= 1'b0;
      base_q     <= 1'b0;
    end else if (capture_en) begin
      captured_q <= 1'b1;
      base_q     <= pin_be;
    end
  end

endmodule

// File: rtl/stat_mode_decode.sv
module stat_mode_decode
  import stat_cfg_pkg::*;
(
  input  logic [1:0]      mode_fld,
  input  logic [CU_N-1:0] cu_fld,
  input  logic            rev_endian,
  input  logic            base_be,
  output logic [1:0]      mode_o,
  output logic [CU_N-2:0] cp_usable_o,
  output logic            ext_isa_o,
  output logic            big_endian_o
);

  priv_mode_e mode_eff;
  logic       is_kernel;
  logic       is_user;

  always_comb begin
    unique case (priv_mode_e'(mode_fld))
      MODE_KERNEL: mode_eff = MODE_KERNEL;
      MODE_SUPER:  mode_eff = MODE_SUPER;
      default:     mode_eff = MODE_USER;
    endcase
    is_kernel    = (mode_eff == MODE_KERNEL);
    is_user      = (mode_eff == MODE_USER);
    mode_o       = mode_eff;
    ext_isa_o    = !is_user || cu_fld[CU_N-1];
    big_endian_o = base_be ^ (is_user && rev_endian);
  end

  for (genvar gi = 0; gi < CU_N - 1; gi++) begin : g_cu
    if (gi == 0) begin : g_sys
      assign cp_usable_o[gi] = cu_fld[gi] | is_kernel;
    end else begin : g_plain
      assign cp_usable_o[gi] = cu_fld[gi];
    end
  end

endmodule

// File: rtl/stat_irq_gate.sv
module stat_irq_gate #(
  parameter int unsigned LINES = 8
) (
  input  logic [LINES-1:0] mask,
  input  logic [LINES-1:0] pend,
  input  logic             gie,
  output logic             req
);

  logic [LINES-1:0] hit;

  for (genvar gi = 0; gi < LINES; gi++) begin : g_line
    assign hit[gi] = mask[gi] & pend[gi];
  end

  always_comb begin
    req = gie & (|hit);
  end

endmodule

// File: rtl/sysctl_status_reg.sv
module sysctl_status_reg
  import stat_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             base_big_endian_i,
  input  logic [IRQ_N-1:0] irq_pend_i,
  output logic [1:0]       mode_o,
  output logic [CU_N-2:0]  cp_usable_o,
  output logic             ext_isa_o,
  output logic             big_endian_o,
  output logic             irq_req_o
);

  logic [REG_W-1:0] stat_q;
  logic             base_be;

  stat_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en_i),
    .wr_data (wr_data_i),
    .stat_q  (stat_q)
  );

  stat_base_endian u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_be  (base_big_endian_i),
    .base_be (base_be)
  );

  stat_mode_decode u_dec (
    .mode_fld     (stat_q[MODE_LSB +: 2]),
    .cu_fld       (stat_q[CU_LSB +: CU_N]),
    .rev_endian   (stat_q[RE_BIT]),
    .base_be      (base_be),
    .mode_o       (mode_o),
    .cp_usable_o  (cp_usable_o),
    .ext_isa_o    (ext_isa_o),
    .big_endian_o (big_endian_o)
  );

  stat_irq_gate #(.LINES(IRQ_N)) u_irq (
    .mask (stat_q[IM_LSB +: IRQ_N]),
    .pend (irq_pend_i),
    .gie  (stat_q[IE_BIT]),
    .req  (irq_req_o)
  );

  assign rd_data_o = stat_q;

endmodule

// File: rtl/sysctl_status_reg_chk.sv
module sysctl_status_reg_chk
  import stat_cfg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic [IRQ_N-1:0] irq_pend_i,
  input logic [1:0]       mode_o,
  input logic [CU_N-2:0]  cp_usable_o,
  input logic             ext_isa_o,
  input logic             big_endian_o,
  input logic             irq_req_o,
  input logic             base_be_i
);

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> rd_data_o == ($past(wr_data_i) & WR_MASK));

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data_o & ~WR_MASK) == '0) && !rd_data_o[RP_BIT]);

  assert_no_rsvd_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'b11);

  assert_kernel_cp0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b00) |-> cp_usable_o[0]);

  assert_ext_priv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'b10) |-> ext_isa_o);

  assert_endian_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o != 2'b10) || !rd_data_o[RE_BIT]) |-> (big_endian_o == base_be_i));

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (rd_data_o[IE_BIT] && ((irq_pend_i & rd_data_o[IM_LSB +: IRQ_N]) != '0)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(rd_data_o));

endmodule

bind sysctl_status_reg sysctl_status_reg_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en_i      (wr_en_i),
  .wr_data_i    (wr_data_i),
  .rd_data_o    (rd_data_o),
  .irq_pend_i   (irq_pend_i),
  .mode_o       (mode_o),
  .cp_usable_o  (cp_usable_o),
  .ext_isa_o    (ext_isa_o),
  .big_endian_o (big_endian_o),
  .irq_req_o    (irq_req_o),
  .base_be_i    (base_be)
);

// File: tb/sysctl_status_reg_tb_top.sv
module sysctl_status_reg_tb_top;

  localparam logic [31:0] MASK = 32'hF200_FF19;
  localparam int NV = 13;
  // {write data, pending, exp mode, exp cp_usable, exp ext, exp big-endian, exp irq}
  localparam logic [47:0] VEC [0:NV-1] = '{
    {32'h0000_0000, 8'hFF, 2'b00, 3'b001, 1'b1, 1'b1, 1'b0},
    {32'h0000_FF01, 8'h10, 2'b00, 3'b001, 1'b1, 1'b1, 1'b1},
    {32'h0200_0008, 8'hFF, 2'b01, 3'b000, 1'b1, 1'b1, 1'b0},
    {32'h0200_0010, 8'hFF, 2'b10, 3'b000, 1'b0, 1'b0, 1'b0},
    {32'h8000_0018, 8'h00, 2'b10, 3'b000, 1'b1, 1'b1, 1'b0},
    {32'h7000_0010, 8'h00, 2'b10, 3'b111, 1'b0, 1'b1, 1'b0},
    {32'h0000_0511, 8'h02, 2'b10, 3'b000, 1'b0, 1'b1, 1'b0},
    {32'h0000_0511, 8'h04, 2'b10, 3'b000, 1'b0, 1'b1, 1'b1},
    {32'h0000_0510, 8'h04, 2'b10, 3'b000, 1'b0, 1'b1, 1'b0},
    {32'h2000_0000, 8'h00, 2'b00, 3'b011, 1'b1, 1'b1, 1'b0},
    {32'h0200_0018, 8'h00, 2'b10, 3'b000, 1'b0, 1'b0, 1'b0},
    {32'h8200_0008, 8'h00, 2'b01, 3'b000, 1'b1, 1'b1, 1'b0},
    {32'h0200_0000, 8'h00, 2'b00, 3'b001, 1'b1, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en_i;
  logic [31:0] wr_data_i;
  logic [31:0] rd_data_o;
  logic        base_big_endian_i;
  logic [7:0]  irq_pend_i;
  logic [1:0]  mode_o;
  logic [2:0]  cp_usable_o;
  logic        ext_isa_o;
  logic        big_endian_o;
  logic        irq_req_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sysctl_status_reg dut_i (
    .clk               (clk),
    .rst_n             (rst_n),
    .wr_en_i           (wr_en_i),
    .wr_data_i         (wr_data_i),
    .rd_data_o         (rd_data_o),
    .base_big_endian_i (base_big_endian_i),
    .irq_pend_i        (irq_pend_i),
    .mode_o            (mode_o),
    .cp_usable_o       (cp_usable_o),
    .ext_isa_o         (ext_isa_o),
    .big_endian_o      (big_endian_o),
    .irq_req_o         (irq_req_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply_reset(input logic pin);
    rst_n = 1'b0;
    wr_en_i = 1'b0;
    wr_data_i = '0;
    base_big_endian_i = pin;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1;
    wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    irq_pend_i = 8'hFF;
    apply_reset(1'b1);
    // R1: reset state
    check("R1 rd_data", rd_data_o, 32'h0);
    check("R1 mode", 32'(mode_o), 32'h0);
    check("R1 irq", 32'(irq_req_o), 32'h0);
    check("R7 base after reset", 32'(big_endian_o), 32'h1);

    // Table walk: R2 readback, R4 mode, R5 usable, R6 ext, R7 endian, R9 irq
    for (int i = 0; i < NV; i++) begin
      logic [31:0] w;
      logic [7:0]  p;
      logic [1:0]  em;
      logic [2:0]  ec;
      logic        ee, eb, ei;
      {w, p, em, ec, ee, eb, ei} = VEC[i];
      irq_pend_i = p;
      do_write(w);
      check("R2 readback", rd_data_o, w & MASK);
      check("R4 mode", 32'(mode_o), 32'(em));
      check("R5 cp_usable", 32'(cp_usable_o), 32'(ec));
      check("R6 ext_isa", 32'(ext_isa_o), 32'(ee));
      check("R7 endian", 32'(big_endian_o), 32'(eb));
      check("R9 irq", 32'(irq_req_o), 32'(ei));
    end

    // R3: reserved and reduced-power bits ignore writes
    do_write(32'hFFFF_FFFF);
    check("R3 all-ones readback", rd_data_o, 32'hF200_FF19);
    check("R3 rp bit", 32'(rd_data_o[27]), 32'h0);

    // R10: no strobe, data bus toggling
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      wr_data_i = 32'h0000_0000 ^ (32'h1234_5678 << k);
    end
    @(negedge clk);
    check("R10 hold", rd_data_o, 32'hF200_FF19);

    // R8: later pin change ignored
    do_write(32'h0000_0000);
    base_big_endian_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 pin change ignored", 32'(big_endian_o), 32'h1);

    // R8 / R1: new reset captures little-endian base
    irq_pend_i = 8'hFF;
    apply_reset(1'b0);
    check("R1 rd_data second reset", rd_data_o, 32'h0);
    check("R1 irq second reset", 32'(irq_req_o), 32'h0);
    check("R8 new base kernel", 32'(big_endian_o), 32'h0);
    base_big_endian_i = 1'b1;
    do_write(32'h0200_0010);
    check("R7 user reversed little base", 32'(big_endian_o), 32'h1);
    do_write(32'h0000_0010);
    check("R8 user unreversed keeps base", 32'(big_endian_o), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule